// File: doc/BRIEF.md
# External Status Interrupt Latch

This block watches a small group of already-synchronised status lines (modem control inputs and a break indication) together with an internally kept transmit underrun/end-of-message flag. While nothing is pending, a registered snapshot follows these inputs one clock behind. The first difference between the inputs and the snapshot freezes the snapshot on the new value and makes an interrupt pending. Because the snapshot is frozen, a pulse that is too short for software to see is still held until it has been read.

Software acknowledges the interrupt with a status-clear strobe. At that moment the block compares the live inputs with the frozen snapshot. If a later change is still present, the snapshot is reloaded and a new interrupt is raised at once. This is a one-deep queue. If the later change has already gone back to the frozen value, no new interrupt is raised. The underrun/end-of-message flag is set when CRC transmission starts or an abort is issued. A dedicated clear strobe clears it, but only while the transmitter is enabled. With the transmitter disabled, the clear strobe instead produces a status interrupt whose snapshot shows the flag as zero.

Top module: `esi_status_latch`

## Requirements
- R1: While `rst_n` is low, `stat_out` and `irq` are 0. On the first clock after release, the snapshot loads the live inputs and no interrupt is raised.
- R2: With nothing pending, a clock where the live vector {flag, `stat_in`} differs from `stat_out` sets the pending state at that edge, and `stat_out` shows the new vector. `stat_out[NUM_LINES]` is the underrun/end-of-message flag and `stat_out[NUM_LINES-1:0]` mirrors `stat_in`.
- R3: While an interrupt is pending and `clr_cmd` is low, `stat_out` does not change and `irq` stays high, whatever the inputs do.
- R4: A `clr_cmd` edge where the live vector equals the frozen snapshot clears the pending state, and the latch becomes transparent again. A pulse that returned to the frozen value before the clear therefore raises nothing.
- R5: A `clr_cmd` edge where the live vector differs from the frozen snapshot keeps an interrupt pending, and `stat_out` takes the live vector.
- R6: A `crc_start` or `abort_cmd` strobe sets the flag at that edge. A set strobe takes priority over `eom_clr` in the same cycle.
- R7: `eom_clr` with `tx_en` high clears the flag at that edge.
- R8: `eom_clr` with `tx_en` low leaves the flag set. If nothing is pending, or `clr_cmd` is high in the same cycle, an interrupt becomes pending with `stat_out[NUM_LINES]` shown as 0.
- R9: `irq` is the pending state gated by `irq_en`. Lowering `irq_en` masks `irq` without losing the pending state.
- R10: `eom_clr` with `tx_en` low while an interrupt is pending and `clr_cmd` is low has no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_in | input | NUM_LINES | Synchronised status lines |
| irq_en | input | 1 | Master status-interrupt enable |
| clr_cmd | input | 1 | Status-clear (re-enable) command strobe |
| eom_clr | input | 1 | Clear strobe for the underrun/end-of-message flag |
| crc_start | input | 1 | Strobe marking the start of CRC transmission |
| tx_en | input | 1 | Transmitter enable |
| abort_cmd | input | 1 | Abort command strobe |
| stat_out | output | NUM_LINES+1 | Latched status: flag in the top bit, lines below it |
| irq | output | 1 | Interrupt request |

## Verification
A snapshot register that is frozen too late, or released too early, shows at `stat_out` on the first clock after the triggering input change. A faulty queue decision shows at `irq` on the edge right after the clear strobe. The bench sweeps every pair of starting and changed line values, and for each pair runs the dropped-pulse case and the persisting-change case, so a wrong comparison cannot go unseen. A flag held wrongly in the disabled-transmitter case appears two edges later, as an unexpected or missing re-interrupt after the clear.

// File: rtl/esi_pkg.sv
package esi_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_TRACK = 2'd1,
    ACT_FORCE = 2'd2,
    ACT_PRIME = 2'd3
  } snap_act_e;

  // True when two status vectors disagree in any bit.
  function automatic logic vec_moved(input logic [31:0] a, input logic [31:0] b);
    return (a ^ b) != 32'd0;
  endfunction

  // Copy of a vector with one bit forced low.
  function automatic logic [31:0] drop_bit(input logic [31:0] v, input int idx);
    logic [31:0] m;
    m = 32'd1 << idx;
    return v & ~m;
  endfunction
endpackage

// File: rtl/esi_eom_flag.sv
module esi_eom_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic crc_start,
  input  logic abort_cmd,
  input  logic eom_clr,
  input  logic tx_en,
  output logic eom_live
);
  logic set_ev;
  logic clr_ev;

  assign set_ev = crc_start | abort_cmd;
  assign clr_ev = eom_clr & tx_en & ~set_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)      eom_live <= 1'b0;
    else if (set_ev) eom_live <= 1'b1;
    else if (clr_ev) eom_live <= 1'b0;
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_start || abort_cmd) |=> eom_live);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_clr && tx_en && !crc_start && !abort_cmd) |=> !eom_live);
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_clr && !tx_en && !crc_start && !abort_cmd) |=> $stable(eom_live));
endmodule

// File: rtl/esi_change_det.sv
module esi_change_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic         clr,
  input  logic         force_req,
  output logic [W-1:0] snap,
  output logic         pending
);
  import esi_pkg::*;

  logic      primed;
  logic      open_win;
  logic      moved;
  logic [W-1:0] forced_view;
  snap_act_e act;

  assign open_win    = ~pending | clr;
  assign moved       = vec_moved(32'(live), 32'(snap));
  assign forced_view = W'(drop_bit(32'(live), W - 1));

  always_comb begin
    if (!primed)                    act = ACT_PRIME;
    else if (open_win && force_req) act = ACT_FORCE;
    else if (open_win)              act = ACT_TRACK;
    else                            act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap    <= '0;
      pending <= 1'b0;
      primed  <= 1'b0;
    end else begin
      primed <= 1'b1;
      unique case (act)
        ACT_PRIME: begin snap <= live;        pending <= 1'b0;  end
        ACT_FORCE: begin snap <= forced_view; pending <= 1'b1;  end
        ACT_TRACK: begin snap <= live;        pending <= moved; end
        default:   begin snap <= snap;        pending <= pending; end
      endcase
    end
  end

  assert_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !pending && !force_req && live != snap) |=> (pending && snap == $past(live)));
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> ($stable(snap) && pending));
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && clr && !force_req && live == snap) |=> !pending);
  assert_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && pending && clr && !force_req && live != snap) |=> (pending && snap == $past(live)));
  assert_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && force_req && open_win) |=> (pending && !snap[W-1]));
endmodule

// File: rtl/esi_status_latch.sv
module esi_status_latch #(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] stat_in,
  input  logic                 irq_en,
  input  logic                 clr_cmd,
  input  logic                 eom_clr,
  input  logic                 crc_start,
  input  logic                 tx_en,
  input  logic                 abort_cmd,
  output logic [NUM_LINES:0]   stat_out,
  output logic                 irq
);
  localparam int VW = NUM_LINES + 1;

  logic          eom_live;
  logic          pending;
  logic          force_req;
  logic [VW-1:0] live_vec;

  esi_eom_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_start (crc_start),
    .abort_cmd (abort_cmd),
    .eom_clr   (eom_clr),
    .tx_en     (tx_en),
    .eom_live  (eom_live)
  );

  assign live_vec  = {eom_live, stat_in};
  assign force_req = eom_clr & ~tx_en;

  esi_change_det #(.W(VW)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (live_vec),
    .clr       (clr_cmd),
    .force_req (force_req),
    .snap      (stat_out),
    .pending   (pending)
  );

  assign irq = pending & irq_en;

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_cmd && eom_clr && !tx_en) |=> ($stable(stat_out) && pending));
endmodule

// File: tb/esi_status_latch_test.sv
module esi_status_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] stat_in = 4'h0;
  logic       irq_en = 1'b1;
  logic       clr_cmd = 1'b0;
  logic       eom_clr = 1'b0;
  logic       crc_start = 1'b0;
  logic       tx_en = 1'b1;
  logic       abort_cmd = 1'b0;
  logic [4:0] stat_out;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  esi_status_latch #(.NUM_LINES(4)) uut (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .irq_en(irq_en),
    .clr_cmd(clr_cmd), .eom_clr(eom_clr), .crc_start(crc_start),
    .tx_en(tx_en), .abort_cmd(abort_cmd), .stat_out(stat_out), .irq(irq)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Two clear edges leave nothing pending with lines at v.
  task automatic settle(input logic [3:0] v);
    stat_in = v;
    clr_cmd = 1'b1;
    tick();
    tick();
    clr_cmd = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_cmd = 1'b1;
    tick();
    clr_cmd = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] c;
    // R1: reset state and priming without interrupt
    stat_in = 4'hA;
    tick();
    tick();
    chk(stat_out == 5'h00 && !irq, "R1 in reset", {irq, stat_out}, 0);
    rst_n = 1'b1;
    tick();
    chk(stat_out == 5'h0A && !irq, "R1 primed", {irq, stat_out}, 5'h0A);
    tick();
    chk(!irq, "R1 no irq after prime", irq, 0);

    // Sweep of all start/change pairs (R2, R3, R4, R5)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        settle(4'(a));
        chk(stat_out == {1'b0, 4'(a)} && !irq, "R4 settled", {irq, stat_out}, a);
        stat_in = 4'(b);
        tick();
        chk(irq == (a != b) && stat_out[3:0] == 4'(b), "R2 change", {irq, stat_out}, {(a != b), 1'b0, 4'(b)});
        if (a != b) begin
          c = 4'(b) ^ 4'h5;
          stat_in = c;
          tick();
          chk(irq && stat_out[3:0] == 4'(b), "R3 frozen", {irq, stat_out}, {1'b1, 1'b0, 4'(b)});
          stat_in = 4'(b);
          tick();
          pulse_clr();
          chk(!irq && stat_out[3:0] == 4'(b), "R4 pulse dropped", {irq, stat_out}, {1'b0, 1'b0, 4'(b)});
          stat_in = 4'(a);
          tick();
          stat_in = c;
          pulse_clr();
          chk(irq == (c != 4'(a)) && stat_out[3:0] == c, "R5 queued", {irq, stat_out}, {(c != 4'(a)), 1'b0, c});
        end
      end
    end

    // R6: start of CRC sets the flag
    settle(4'h0);
    crc_start = 1'b1;
    tick();
    crc_start = 1'b0;
    tick();
    chk(stat_out == 5'h10 && irq, "R6 crc start", {irq, stat_out}, 6'h30);
    settle(4'h0);
    chk(stat_out == 5'h10 && !irq, "R6 flag stays", {irq, stat_out}, 5'h10);

    // R7: clear with transmitter enabled
    tx_en = 1'b1;
    eom_clr = 1'b1;
    tick();
    eom_clr = 1'b0;
    tick();
    chk(stat_out == 5'h00 && irq, "R7 clear enabled", {irq, stat_out}, 6'h20);
    settle(4'h0);

    // R6: abort sets the flag
    abort_cmd = 1'b1;
    tick();
    abort_cmd = 1'b0;
    tick();
    chk(stat_out == 5'h10 && irq, "R6 abort", {irq, stat_out}, 6'h30);
    settle(4'h0);

    // R8: clear with transmitter disabled, nothing pending
    tx_en = 1'b0;
    eom_clr = 1'b1;
    tick();
    eom_clr = 1'b0;
    chk(stat_out == 5'h00 && irq, "R8 forced view", {irq, stat_out}, 6'h20);
    pulse_clr();
    chk(stat_out == 5'h10 && irq, "R8 flag kept", {irq, stat_out}, 6'h30);
    settle(4'h0);
    chk(stat_out == 5'h10 && !irq, "R8 settled", {irq, stat_out}, 5'h10);

    // R10: disabled clear while pending without status clear
    stat_in = 4'h1;
    tick();
    eom_clr = 1'b1;
    tick();
    eom_clr = 1'b0;
    chk(stat_out == 5'h11 && irq, "R10 no effect", {irq, stat_out}, 6'h31);
    settle(4'h1);
    chk(stat_out == 5'h11 && !irq, "R10 flag still set", {irq, stat_out}, 5'h11);

    // R8: disabled clear accompanied by status clear while pending
    stat_in = 4'h3;
    tick();
    eom_clr = 1'b1;
    clr_cmd = 1'b1;
    tick();
    eom_clr = 1'b0;
    clr_cmd = 1'b0;
    chk(stat_out == 5'h03 && irq, "R8 with clear", {irq, stat_out}, 6'h23);
    settle(4'h3);

    // R6: set wins over clear in the same cycle
    tx_en = 1'b1;
    eom_clr = 1'b1;
    tick();
    eom_clr = 1'b0;
    tick();
    settle(4'h3);
    chk(stat_out == 5'h03 && !irq, "R7 cleared", {irq, stat_out}, 5'h03);
    crc_start = 1'b1;
    eom_clr = 1'b1;
    tick();
    crc_start = 1'b0;
    eom_clr = 1'b0;
    tick();
    chk(stat_out == 5'h13 && irq, "R6 set priority", {irq, stat_out}, 6'h33);
    settle(4'h3);

    // R9: master enable masks without losing pending
    irq_en = 1'b0;
    stat_in = 4'h7;
    tick();
    chk(!irq && stat_out == 5'h17, "R9 masked", {irq, stat_out}, 5'h17);
    tick();
    irq_en = 1'b1;
    #1;
    chk(irq, "R9 unmasked", irq, 1);
    settle(4'h7);
    chk(!irq, "R9 cleared", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule